// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. A cycle starts on a rising clock edge when one of two active-low address-status strobes is sampled low. One strobe belongs to the processor and the other to the cache controller. On that edge the block captures the external word address. The upper bits are held for the whole burst. The two low bits then step through a four-beat sequence, moving one beat on each edge where the active-low advance input is sampled low.

The processor strobe only counts while the first chip select is low. The cache-controller strobe always counts. A static order pin selects the beat order: low gives linear order, high gives interleaved order. The block drives the full internal word address and a flag that shows a burst is in progress. The flag drops when the fourth beat is advanced past.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is all zeros and `burst_act` is 0.
- R2: When `cpu_ads_n` is sampled low while `cs1_n` is low, then one clock later `addr_out` equals the sampled `addr_in` and `burst_act` is 1.
- R3: When `cpu_ads_n` is sampled low while `cs1_n` is high, the processor strobe has no effect. If `cc_ads_n` and `adv_n` are both high on that edge, `addr_out` and `burst_act` keep their values.
- R4: When `cc_ads_n` is sampled low, then one clock later `addr_out` equals the sampled `addr_in` and `burst_act` is 1, whatever the level of `cs1_n`.
- R5: While a burst runs with no strobe accepted, `addr_out[ADDR_W-1:2]` stays at its loaded value, even if `addr_in` changes.
- R6: With no strobe accepted and `adv_n` high, `addr_out` and `burst_act` keep their values.
- R7: With `order_sel` = 0 (linear), the low two bits of beat k (k = 0..3) equal the loaded low bits plus k, modulo 4. A start of 2 gives 2, 3, 0, 1.
- R8: With `order_sel` = 1 (interleaved), the low two bits of beat k equal the loaded low bits XOR k. A start of 1 gives 1, 0, 3, 2.
- R9: An accepted strobe during a burst loads the new address and restarts at beat 0. A low `adv_n` on that same edge is ignored.
- R10: Advancing from beat 3 clears `burst_act` and leaves `addr_out` unchanged. While `burst_act` is 0 and no strobe is accepted, `adv_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ads_n | input | 1 | Processor address-status strobe, active low |
| cc_ads_n | input | 1 | Cache-controller address-status strobe, active low |
| cs1_n | input | 1 | First chip select, active low; gates the processor strobe |
| adv_n | input | 1 | Burst advance request, active low |
| order_sel | input | 1 | Static beat order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Internal word address for the current beat |
| burst_act | output | 1 | High while a burst is in progress |

## Verification
The beat counter, the captured base bits and the active flag all feed `addr_out` or `burst_act` directly. A wrong internal state therefore shows at the ports on the edge after it arises. Examples are a counter that steps without an advance, a wrong order function, or a processor strobe taken with the chip select high. Any of these gives a wrong low address pair or flag in that same cycle. The captured upper bits are compared on every beat. A late or stray reload of them shows as soon as `addr_in` differs from the loaded address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              act;
    } low_state_t;

endpackage

// File: rtl/seq_strobe_ctrl.sv
module seq_strobe_ctrl (
    input  logic cpu_ads_n,
    input  logic cc_ads_n,
    input  logic cs1_n,
    input  logic adv_n,
    input  logic act,
    output logic load,
    output logic step
);
    logic cpu_take;

    always_comb begin
        cpu_take = !cpu_ads_n && !cs1_n;
        load     = cpu_take || !cc_ads_n;
        step     = !load && !adv_n && act;
    end
endmodule

// File: rtl/seq_low_order.sv
module seq_low_order
    import burst_seq_pkg::*;
(
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] low
);
    always_comb begin
        if (order_e'(order_sel) == ORDER_INTERLEAVE)
            low = base ^ beat;
        else
            low = base + beat;
    end

    always_comb begin
        if (beat == '0)
            a_first_beat_r7: assert (low == base);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ads_n,
    input  logic              cc_ads_n,
    input  logic              cs1_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_act
);
    localparam int UP_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    low_state_t        low_d, low_q;
    logic [UP_W-1:0]   upper_d, upper_q;
    logic              load, step;
    logic [BEAT_W-1:0] low_bits;

    seq_strobe_ctrl u_ctrl (
        .cpu_ads_n (cpu_ads_n),
        .cc_ads_n  (cc_ads_n),
        .cs1_n     (cs1_n),
        .adv_n     (adv_n),
        .act       (low_q.act),
        .load      (load),
        .step      (step)
    );

    seq_low_order u_order (
        .base      (low_q.base),
        .beat      (low_q.beat),
        .order_sel (order_sel),
        .low       (low_bits)
    );

    always_comb begin
        low_d   = low_q;
        upper_d = upper_q;
        if (load) begin
            upper_d    = addr_in[ADDR_W-1:BEAT_W];
            low_d.base = addr_in[BEAT_W-1:0];
            low_d.beat = '0;
            low_d.act  = 1'b1;
        end else if (step) begin
            if (low_q.beat == LAST_BEAT)
                low_d.act = 1'b0;
            else
                low_d.beat = low_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            upper_q <= '0;
        end else begin
            low_q   <= low_d;
            upper_q <= upper_d;
        end
    end

    assign addr_out  = {upper_q, low_bits};
    assign burst_act = low_q.act;

    p_cpu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ads_n && !cs1_n) |=> (addr_out == $past(addr_in)) && burst_act);

    p_cpu_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ads_n && cs1_n && cc_ads_n && adv_n) |=> $stable(addr_out) && $stable(burst_act));

    p_cc_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_ads_n |=> (addr_out == $past(addr_in)) && burst_act);

    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && cc_ads_n && (cpu_ads_n || cs1_n))
        |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_ads_n && (cpu_ads_n || cs1_n) && adv_n) |=> $stable(addr_out) && $stable(burst_act));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_act && cc_ads_n && (cpu_ads_n || cs1_n)) |=> $stable(addr_out) && !burst_act);
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_ads_n = 1'b1, cc_ads_n = 1'b1, cs1_n = 1'b1, adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          burst_act;

    int checks = 0;
    int fails  = 0;

    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_base = '0, m_beat = '0;
    logic          m_act = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .cc_ads_n(cc_ads_n),
        .cs1_n(cs1_n), .adv_n(adv_n), .order_sel(order_sel),
        .addr_in(addr_in), .addr_out(addr_out), .burst_act(burst_act)
    );

    function automatic logic [1:0] beat_low(logic [1:0] b, logic [1:0] k, logic ord);
        return ord ? (b ^ k) : (b + k);
    endfunction

    task automatic check(string req, logic [AW-1:0] exp_a, logic exp_v);
        checks++;
        if (addr_out !== exp_a || burst_act !== exp_v) begin
            fails++;
            $display("FAIL %s: addr_out=%h burst_act=%b expected addr_out=%h burst_act=%b",
                     req, addr_out, burst_act, exp_a, exp_v);
        end
    endtask

    task automatic cycle(logic cpu, logic cc, logic cs, logic adv, logic [AW-1:0] a, string req);
        cpu_ads_n = cpu; cc_ads_n = cc; cs1_n = cs; adv_n = adv; addr_in = a;
        @(posedge clk);
        if ((!cpu && !cs) || !cc) begin
            m_up = a[AW-1:2]; m_base = a[1:0]; m_beat = 0; m_act = 1;
        end else if (!adv && m_act) begin
            if (m_beat == 3) m_act = 0; else m_beat = m_beat + 1;
        end
        @(negedge clk);
        check(req, {m_up, beat_low(m_base, m_beat, order_sel)}, m_act);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", '0, 1'b0);
        rst_n = 1'b1;

        cycle(1, 1, 1, 0, 20'hABCDE, "R10 idle advance");
        order_sel = 0;
        cycle(0, 1, 0, 1, 20'h12346, "R2");
        cycle(1, 1, 1, 1, 20'hFFFFF, "R6 hold");
        for (int k = 0; k < 3; k++) cycle(1, 1, 1, 0, 20'h00000, "R7 linear R5");
        cycle(1, 1, 1, 0, 20'h55555, "R10 end");
        cycle(1, 1, 1, 0, 20'h55555, "R10 after end");
        cycle(0, 1, 1, 1, 20'h77777, "R3 blocked");
        order_sel = 1;
        cycle(1, 0, 1, 1, 20'h0F0F1, "R4");
        for (int k = 0; k < 3; k++) cycle(1, 1, 0, 0, 20'h11111, "R8 interleave");
        cycle(1, 1, 1, 0, 20'h3C3C2, "R8 advance");
        cycle(1, 0, 1, 0, 20'h3C3C2, "R9 reload");
        cycle(0, 1, 0, 0, 20'h24683, "R9 cpu reload");
        cycle(1, 1, 1, 0, 20'h0, "R8 after reload");

        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) order_sel = $urandom_range(0, 1);
            cycle(($urandom_range(0, 7) != 0), ($urandom_range(0, 9) != 0),
                  $urandom_range(0, 1), $urandom_range(0, 1),
                  AW'($urandom), "R5 R6 R7 R8 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule